// File: doc/BRIEF.md
# Register-Mapped Serial Transceiver

The block is an asynchronous serial transmitter and receiver behind a simple word-indexed register port. Software queues bytes for transmission by writing a transmit data register. It collects received bytes by reading a receive data register. Each side has a small FIFO. The status of each FIFO comes back in the upper bit of the same word that carries the data, so a single read tells software whether a push is allowed or whether the returned byte is valid.

The bit timer is programmable: one bit lasts divisor+1 clock cycles. For example, a divisor of 138 at a 16 MHz clock gives close to 115200 baud. Transmit and receive each have their own enable. One interrupt output is raised while the receive FIFO holds more bytes than a programmable watermark, and only when that interrupt source is enabled.

Top module: `serial_port`

## Requirements
- R1: Every bit on the line lasts exactly divisor+1 clock cycles. The divisor sits in register index 5, bits [DIV_W-1:0], and resets to DIV_RST.
- R2: Bit 0 of register index 2 enables transmission. While it is clear, no frame starts and queued bytes stay in the transmit FIFO.
- R3: A read of register index 0 returns the transmit-full flag in bit 31. A write to index 0 while that flag is set is discarded.
- R4: A read of register index 1 returns the received byte in bits [7:0] and an empty flag in bit 31. The byte is valid only when bit 31 is 0.
- R5: A read of index 1 while the receive FIFO is not empty removes one byte, and bytes come out in arrival order. A read while the FIFO is empty changes nothing.
- R6: Bit 0 of register index 3 enables reception. Frames that arrive while it is clear are not stored.
- R7: irq_o is high exactly while bit 0 of register index 4 is set and the receive FIFO count is greater than the watermark in register index 3, bits [16+CNT_W-1:16].
- R8: The line idles high. A frame is one low start bit, 8 data bits LSB first, then one high stop bit.
- R9: The receiver checks the start bit at its midpoint and samples each data bit at its centre. A frame whose stop bit samples low is discarded, and reception resumes only after the line returns high.
- R10: After reset, tx_o is high, irq_o is low, the transmit-full flag is 0 and the receive empty flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops receive data) |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of reg_re_i |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| irq_o | output | 1 | Receive watermark interrupt |

## Verification
The bench builds the block with FIFO_DEPTH=4 and DIV_RST=3. With a four-clock bit, each frame takes about forty cycles. Four writes then fill the transmit FIFO, so the full flag and the discarded extra push can be observed cheaply. The divisor is also rewritten to 5 to show that the bit length follows the register rather than the reset value. Watermark 1 lets the interrupt threshold be crossed with only two received frames.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned FLAG_BIT = 31;
  localparam int unsigned WM_LSB   = 16;

  localparam logic [REG_AW-1:0] A_TXDATA = 3'd0;
  localparam logic [REG_AW-1:0] A_RXDATA = 3'd1;
  localparam logic [REG_AW-1:0] A_TXCTRL = 3'd2;
  localparam logic [REG_AW-1:0] A_RXCTRL = 3'd3;
  localparam logic [REG_AW-1:0] A_IRQEN  = 3'd4;
  localparam logic [REG_AW-1:0] A_DIV    = 3'd5;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_push_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             avail_i,
  input  logic [7:0]       data_i,
  output logic             pop_o,
  output logic             tx_o
);
  logic             busy_q;
  logic [9:0]       sh_q;
  logic [3:0]       idx_q;
  logic [DIV_W-1:0] cnt_q;

  assign pop_o = en_i & avail_i & ~busy_q;
  assign tx_o  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, data_i, 1'b0};
      idx_q  <= '0;
      cnt_q  <= div_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (idx_q == 4'd9) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {1'b1, sh_q[9:1]};
          idx_q <= idx_q + 1'b1;
          cnt_q <= div_i;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_start_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == 4'd0) |-> !tx_o);
  assert_timer_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $stable(div_i)) |-> cnt_q <= div_i);
endmodule

// File: rtl/serial_rx.sv
module serial_rx import serial_pkg::*; #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rx_i,
  output logic             valid_o,
  output logic [7:0]       data_o
);
  logic [1:0]       sync_q;
  logic             line;
  rx_state_e        st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       idx_q;
  logic [7:0]       sh_q;

  assign line   = sync_q[1];
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: if (en_i && !line) begin
          cnt_q <= div_i >> 1;
          st_q  <= RX_START;
        end
        RX_START: if (cnt_q == '0) begin
          if (line) begin
            st_q <= RX_IDLE;  // false start
          end else begin
            cnt_q <= div_i;
            idx_q <= '0;
            st_q  <= RX_DATA;
          end
        end else cnt_q <= cnt_q - 1'b1;
        RX_DATA: if (cnt_q == '0) begin
          sh_q  <= {line, sh_q[7:1]};
          cnt_q <= div_i;
          idx_q <= idx_q + 1'b1;
          if (idx_q == 3'd7) st_q <= RX_STOP;
        end else cnt_q <= cnt_q - 1'b1;
        RX_STOP: if (cnt_q == '0) begin
          if (line) begin
            valid_o <= 1'b1;
            st_q    <= RX_IDLE;
          end else begin
            st_q <= RX_WAIT_HI;
          end
        end else cnt_q <= cnt_q - 1'b1;
        RX_WAIT_HI: if (line) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assert_one_per_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_wait_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_WAIT_HI) |=> !valid_o);
endmodule

// File: rtl/serial_port.sv
module serial_port import serial_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned DIV_RST    = 138
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tx_en_q, rx_en_q, ie_q;
  logic [CNT_W-1:0] wm_q;
  logic [DIV_W-1:0] div_q;

  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic [7:0]       tx_data;
  logic [CNT_W-1:0] tx_count;
  logic             rx_push, rx_pop, rx_full, rx_empty, rx_valid;
  logic [7:0]       rx_byte, rx_data;
  logic [CNT_W-1:0] rx_count;

  assign tx_push = reg_we_i && (reg_addr_i == A_TXDATA) && !tx_full;
  assign rx_pop  = reg_re_i && (reg_addr_i == A_RXDATA) && !rx_empty;
  assign rx_push = rx_valid && !rx_full;
  assign irq_o   = ie_q && (rx_count > wm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      ie_q    <= 1'b0;
      wm_q    <= '0;
      div_q   <= DIV_W'(DIV_RST);
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_TXCTRL: tx_en_q <= reg_wdata_i[0];
        A_RXCTRL: begin
          rx_en_q <= reg_wdata_i[0];
          wm_q    <= reg_wdata_i[WM_LSB +: CNT_W];
        end
        A_IRQEN:  ie_q  <= reg_wdata_i[0];
        A_DIV:    div_q <= reg_wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_TXDATA: reg_rdata_o[FLAG_BIT] = tx_full;
      A_RXDATA: begin
        reg_rdata_o[FLAG_BIT] = rx_empty;
        reg_rdata_o[7:0]      = rx_data;
      end
      A_TXCTRL: reg_rdata_o[0] = tx_en_q;
      A_RXCTRL: begin
        reg_rdata_o[0]                = rx_en_q;
        reg_rdata_o[WM_LSB +: CNT_W]  = wm_q;
      end
      A_IRQEN:  reg_rdata_o[0] = ie_q;
      A_DIV:    reg_rdata_o[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  serial_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(reg_wdata_i[7:0]),
    .pop_i(tx_pop), .data_o(tx_data),
    .full_o(tx_full), .empty_o(tx_empty), .count_o(tx_count)
  );

  serial_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i, .rst_ni, .en_i(tx_en_q), .div_i(div_q),
    .avail_i(!tx_empty), .data_i(tx_data), .pop_o(tx_pop), .tx_o
  );

  serial_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i, .rst_ni, .en_i(rx_en_q), .div_i(div_q),
    .rx_i, .valid_o(rx_valid), .data_o(rx_byte)
  );

  serial_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_byte),
    .pop_i(rx_pop), .data_o(rx_data),
    .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_count)
  );

  assert_irq_needs_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !rx_empty);
  assert_tx_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_q && !tx_empty) |=> tx_count >= $past(tx_count));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_count <= CNT_W'(FIFO_DEPTH));
endmodule

// File: tb/serial_port_tb.sv
module serial_port_tb_top;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned DIVW  = 16;
  localparam int unsigned DRST  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx = 1'b1;
  logic        tx, irq;

  int n_chk = 0, n_fail = 0;
  int div_cur = DRST;

  always #2.5 clk = ~clk;

  serial_port #(.FIFO_DEPTH(DEPTH), .DIV_W(DIVW), .DIV_RST(DRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  localparam logic [7:0] VEC [6] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h3C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic tx_cap(output logic [7:0] b, output logic ok);
    int t = 0;
    ok = 1'b1;
    b = '0;
    while (tx === 1'b1 && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) ok = 1'b0;
    repeat ((div_cur + 1) / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (div_cur + 1) @(negedge clk);
      b[i] = tx;
    end
    repeat (div_cur + 1) @(negedge clk);
    if (tx !== 1'b1) ok = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx = f[i];
      repeat (div_cur + 1) @(negedge clk);
    end
    rx = 1'b1;
    repeat (div_cur + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        ok;
    int          lows;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 tx idle", {31'b0, tx}, 32'd1);
    chk("R10 irq low", {31'b0, irq}, 32'd0);
    rd(3'd0, d); chk("R10 tx not full", {31'b0, d[31]}, 32'd0);
    rd(3'd1, d); chk("R10 rx empty", {31'b0, d[31]}, 32'd1);
    rd(3'd5, d); chk("R1 divisor reset", d, DRST);

    wr(3'd2, 32'd1);
    wr(3'd3, 32'd1);

    // table walk: R8 framing, R4 data and flag
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, {24'b0, VEC[i]});
      tx_cap(b, ok);
      chk("R8 tx frame", {23'b0, ok, b}, {23'b0, 1'b1, VEC[i]});
      rx_send(VEC[i], 1'b1);
      rd(3'd1, d);
      chk("R4 rx word", d, {24'b0, VEC[i]});
    end
    rd(3'd1, d); chk("R5 empty after drain", {31'b0, d[31]}, 32'd1);
    rd(3'd1, d); chk("R5 empty read no effect", {31'b0, d[31]}, 32'd1);

    // R1 start bit length, default and rewritten divisor
    repeat (10) @(negedge clk);
    wr(3'd0, 32'h01);
    while (tx === 1'b1) @(negedge clk);
    lows = 0;
    while (tx === 1'b0) begin lows++; @(negedge clk); end
    chk("R1 bit length div3", lows, DRST + 1);
    repeat (50) @(negedge clk);
    wr(3'd5, 32'd5); div_cur = 5;
    wr(3'd0, 32'h01);
    while (tx === 1'b1) @(negedge clk);
    lows = 0;
    while (tx === 1'b0) begin lows++; @(negedge clk); end
    chk("R1 bit length div5", lows, 6);
    repeat (70) @(negedge clk);
    wr(3'd5, DRST); div_cur = DRST;

    // R2 / R3 disabled tx, fill, overflow discard
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h11); wr(3'd0, 32'h22); wr(3'd0, 32'h33); wr(3'd0, 32'h44);
    rd(3'd0, d); chk("R3 full flag", {31'b0, d[31]}, 32'd1);
    wr(3'd0, 32'h99);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (tx !== 1'b1) lows++; end
    chk("R2 no frame while off", lows, 0);
    wr(3'd2, 32'd1);
    for (int i = 0; i < 4; i++) begin
      tx_cap(b, ok);
      chk("R3 queued order", {23'b0, ok, b}, {23'b0, 1'b1, 8'(8'h11 * (i + 1))});
    end
    lows = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (tx !== 1'b1) lows++; end
    chk("R3 extra push discarded", lows, 0);
    rd(3'd0, d); chk("R3 full cleared", {31'b0, d[31]}, 32'd0);

    // R5 ordering
    rx_send(8'hC1, 1'b1);
    rx_send(8'hC2, 1'b1);
    rd(3'd1, d); chk("R5 first out", d, 32'hC1);
    rd(3'd1, d); chk("R5 second out", d, 32'hC2);

    // R6 rx disabled
    wr(3'd3, 32'd0);
    rx_send(8'h5A, 1'b1);
    rd(3'd1, d); chk("R6 not stored", {31'b0, d[31]}, 32'd1);

    // R9 bad stop discarded, then recovery
    wr(3'd3, 32'd1);
    rx_send(8'h6B, 1'b0);
    rd(3'd1, d); chk("R9 bad stop dropped", {31'b0, d[31]}, 32'd1);
    rx_send(8'h7C, 1'b1);
    rd(3'd1, d); chk("R9 recovers", d, 32'h7C);

    // R7 watermark interrupt, watermark = 1
    wr(3'd3, 32'h0001_0001);
    wr(3'd4, 32'd1);
    rx_send(8'hD1, 1'b1);
    chk("R7 count1 no irq", {31'b0, irq}, 32'd0);
    rx_send(8'hD2, 1'b1);
    chk("R7 count2 irq", {31'b0, irq}, 32'd1);
    wr(3'd4, 32'd0);
    chk("R7 masked", {31'b0, irq}, 32'd0);
    wr(3'd4, 32'd1);
    chk("R7 unmasked", {31'b0, irq}, 32'd1);
    rd(3'd1, d);
    @(negedge clk);
    chk("R7 below after pop", {31'b0, irq}, 32'd0);
    rd(3'd1, d); chk("R5 last pop", d, 32'hD2);

    finish_run();
  end
endmodule